// File: doc/BRIEF.md
# Tagged Operand Trap Checker

This checker sits beside the execute stage of a simple RISC pipeline. Every data word carries a type tag in its low bits. A word whose lowest bit is 1 is a pointer to an unresolved placeholder value, which is a value that is still being computed elsewhere. Some operations are strict and need the real value. When a strict operation meets such a pointer, the checker raises a trap so that software can wait for the value and then retry the instruction.

There are two strict classes:
- A compute instruction tests both of its data operands.
- A memory instruction tests both of its address operands. A trap from this class is reported as an alignment-style cause.

Non-strict operations never trap. These include moves, parameter passing and stores of a value.

Only bit 0 is tested. A word whose bit 1 is set and whose bit 0 is clear passes without a trap. This differs from the usual integer tag test, which looks at two bits.

The checker samples the instruction on a clock edge. On the next cycle it drives a one-cycle trap pulse together with a cause code, the index of the offending operand and the offending word. In that same cycle it gates the instruction's write-back. An enable input turns checking off for supervisor and handler code.

Top module: `tagged_operand_trap`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, every output is 0.
- R2: When an issued instruction has class 2'b01 (compute) and either operand has bit 0 set, the next cycle shows `trap_valid`=1 and `trap_cause`=2'b01.
- R3: When an issued instruction has class 2'b10 (memory) and either address operand has bit 0 set, the next cycle shows `trap_valid`=1 and `trap_cause`=2'b10.
- R4: Only bit 0 is tested. A strict instruction whose operands have bit 1 set but bit 0 clear does not trap, and its write-back proceeds.
- R5: Classes 2'b00 (move or value store) and 2'b11 (other non-strict) never trap, whatever tags the operands carry.
- R6: Operand A is reported first.
  - If operand A is tagged, `trap_idx`=0, even when operand B is also tagged.
  - If only operand B is tagged, `trap_idx`=1.
  - `trap_word` carries the reported operand on a trap and is 0 otherwise.
- R7: `wb_commit` is 1 in the cycle after an issued instruction that requested write-back and did not trap. It is 0 whenever `trap_valid` is 1.
- R8: While `chk_en` is 0, no trap is produced, and write-back of a requesting instruction proceeds.
- R9: A cycle with `issue_valid`=0 yields `trap_valid`=0, `trap_cause`=2'b00 and `wb_commit`=0 on the next cycle.
- R10: The results for an instruction appear exactly one cycle after it is sampled. A trap lasts one cycle per trapping instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Checking enable; 0 in supervisor/handler mode |
| issue_valid | input | 1 | An instruction is in execute this cycle |
| op_class | input | 2 | 00 move/store-value, 01 compute, 10 memory, 11 other non-strict |
| opnd_a | input | WIDTH | First data or address operand |
| opnd_b | input | WIDTH | Second data or address operand |
| wb_req | input | 1 | Instruction wants to write back |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | 00 none, 01 compute operand, 10 address operand |
| trap_idx | output | 1 | 0 operand A, 1 operand B |
| trap_word | output | WIDTH | Offending operand value |
| wb_commit | output | 1 | Write-back allowed |

## Verification
The hardest case to reach is a strict instruction that looks tagged under a two-bit test but not under the one-bit test. Both operands have bit 1 set and bit 0 clear, and the instruction must still commit. Random 32-bit operands seldom carry exactly that pattern together with a strict class and an enabled checker. For this reason, directed cases build such words on purpose, and a share of the random operands have their two low bits forced to each of the four values. The both-tagged ordering case and the case where checking is disabled on a tagged instruction are built the same way.

// File: rtl/tagged_operand_trap.sv
module tagged_operand_trap #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             issue_valid,
  input  logic [1:0]       op_class,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             wb_req,
  output logic             trap_valid,
  output logic [1:0]       trap_cause,
  output logic             trap_idx,
  output logic [WIDTH-1:0] trap_word,
  output logic             wb_commit
);

  localparam logic [1:0] CLS_COMPUTE   = 2'b01;
  localparam logic [1:0] CLS_MEMORY    = 2'b10;
  localparam logic [1:0] CAUSE_NONE    = 2'b00;
  localparam logic [1:0] CAUSE_OPERAND = 2'b01;
  localparam logic [1:0] CAUSE_ADDRESS = 2'b10;

  logic strict_op, tag_a, tag_b, hit;

  assign strict_op = issue_valid && chk_en &&
                     (op_class == CLS_COMPUTE || op_class == CLS_MEMORY);
  assign tag_a = opnd_a[0];
  assign tag_b = opnd_b[0];
  assign hit   = strict_op && (tag_a || tag_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_cause <= CAUSE_NONE;
      trap_idx   <= 1'b0;
      trap_word  <= '0;
      wb_commit  <= 1'b0;
    end else begin
      trap_valid <= hit;
      trap_cause <= !hit ? CAUSE_NONE :
                    (op_class == CLS_MEMORY) ? CAUSE_ADDRESS : CAUSE_OPERAND;
      trap_idx   <= hit && !tag_a;
      trap_word  <= !hit ? '0 : (tag_a ? opnd_a : opnd_b);
      wb_commit  <= issue_valid && wb_req && !hit;
    end
  end

  assert_wb_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !wb_commit);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!chk_en) |-> !trap_valid);

  assert_nonstrict_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_class) == 2'b00 || $past(op_class) == 2'b11) |-> !trap_valid);

  assert_tagged_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_word[0]);

  assert_a_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(opnd_a[0])) |-> !trap_idx);

  assert_address_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(op_class) == CLS_MEMORY) |-> trap_cause == CAUSE_ADDRESS);

  assert_compute_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(op_class) == CLS_COMPUTE) |-> trap_cause == CAUSE_OPERAND);

  assert_issued_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(issue_valid));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!issue_valid) |-> (!trap_valid && !wb_commit));

endmodule

// File: tb/tagged_operand_trap_tb.sv
module tagged_operand_trap_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, issue_valid = 1'b0, wb_req = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic trap_valid, trap_idx, wb_commit;
  logic [1:0] trap_cause;
  logic [W-1:0] trap_word;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tagged_operand_trap #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .issue_valid(issue_valid),
    .op_class(op_class), .opnd_a(opnd_a), .opnd_b(opnd_b), .wb_req(wb_req),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_idx(trap_idx),
    .trap_word(trap_word), .wb_commit(wb_commit));

  function automatic logic [W+4:0] model(input logic en, input logic v, input logic [1:0] cls,
                                         input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic wb);
    logic strict, t;
    logic [1:0] c;
    strict = v && en && (cls == 2'b01 || cls == 2'b10);
    t = strict && (a[0] || b[0]);
    c = !t ? 2'b00 : (cls == 2'b10 ? 2'b10 : 2'b01);
    return {t, c, t && !a[0], v && wb && !t, t ? (a[0] ? a : b) : {W{1'b0}}};
  endfunction

  function automatic logic [W+4:0] observed();
    return {trap_valid, trap_cause, trap_idx, wb_commit, trap_word};
  endfunction

  task automatic compare(input string req, input logic [W+4:0] act, input logic [W+4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; applies inputs, checks one cycle later (R10)
  task automatic run(input string req, input logic en, input logic v, input logic [1:0] cls,
                     input logic [W-1:0] a, input logic [W-1:0] b, input logic wb);
    logic [W+4:0] exp;
    chk_en = en; issue_valid = v; op_class = cls; opnd_a = a; opnd_b = b; wb_req = wb;
    exp = model(en, v, cls, a, b, wb);
    @(negedge clk);
    compare(req, observed(), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    logic [W+4:0] zero;
    void'($urandom(32'd1234));
    zero = '0;
    chk_en = 1'b1; issue_valid = 1'b1; op_class = 2'b01;
    opnd_a = 32'h1; opnd_b = 32'h1; wb_req = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 in reset", observed(), zero);
    rst_n = 1'b1;
    issue_valid = 1'b0;
    @(negedge clk);
    compare("R1 after reset", observed(), zero);

    run("R2 compute A tagged", 1, 1, 2'b01, 32'h0000_1001, 32'h0000_0004, 1);
    run("R2 R6 compute B only", 1, 1, 2'b01, 32'h0000_0008, 32'hABCD_0003, 1);
    run("R6 both tagged", 1, 1, 2'b01, 32'h1111_1111, 32'h2222_2223, 1);
    run("R3 memory A tagged", 1, 1, 2'b10, 32'h8000_0005, 32'h0, 0);
    run("R3 R6 memory B tagged", 1, 1, 2'b10, 32'h4000_0000, 32'hFFFF_FFFF, 1);
    run("R4 bit1 only compute", 1, 1, 2'b01, 32'h0000_0002, 32'h0000_0006, 1);
    run("R4 bit1 only memory", 1, 1, 2'b10, 32'hFFFF_FFFE, 32'h0000_000A, 1);
    run("R5 move tagged", 1, 1, 2'b00, 32'h0000_0001, 32'h0000_0003, 1);
    run("R5 other tagged", 1, 1, 2'b11, 32'hFFFF_FFFF, 32'h0000_0001, 1);
    run("R8 disabled tagged", 0, 1, 2'b01, 32'h0000_0001, 32'h0000_0001, 1);
    run("R8 disabled memory", 0, 1, 2'b10, 32'h0000_0003, 32'h0, 1);
    run("R9 idle tagged", 1, 0, 2'b01, 32'h0000_0001, 32'h0000_0001, 1);
    run("R7 clean no wb", 1, 1, 2'b01, 32'h0000_0004, 32'h0000_0008, 0);
    run("R10 trap then clean", 1, 1, 2'b01, 32'h0000_0001, 32'h0, 1);
    run("R10 pulse ends", 1, 1, 2'b01, 32'h0000_0010, 32'h0, 1);

    for (int i = 0; i < 2000; i++) begin
      ra = $urandom; rb = $urandom;
      ra[1:0] = 2'($urandom_range(3)); rb[1:0] = 2'($urandom_range(3));
      run("random R2 R3 R4 R5 R6 R7 R8 R9", ($urandom_range(7) != 0), ($urandom_range(5) != 0),
          2'($urandom_range(3)), ra, rb, 1'($urandom_range(1)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule